// File: doc/BRIEF.md
# Mid-Stream CRC-32 Patch Word Solver

This block works out a 32-bit check word that can be dropped into the middle of a byte sequence so that a plain CRC-32 run over the whole sequence, check word included, ends at zero. It holds two CRC registers that run side by side. The forward register takes the bytes that come before the insertion point, in address order. The backward register takes the bytes that come after it, starting from the last byte and moving toward the insertion point. Its last four bytes are the zero bytes that stand in for the check word. The backward register undoes one forward byte step for each byte it takes, so its value is the CRC state the forward pass has to reach just before the placeholder.

The CRC is the reflected 32-bit code with generator 0xEDB88320. It shifts right, so the least significant bit goes first. Both registers start at zero, and no inversion is applied at the input or the output. A start pulse clears both registers. The two streams can then be fed in any interleaving, even in the same cycle. When a finish pulse arrives, the block takes the XOR of the two registers into the output register and raises a done flag for one cycle. The output is given as a word and also as four byte lanes in the order they are stored in memory. Lane 0 goes to the lowest address.

Top module: `crc_midpatch_gen`

## Requirements
- R1: After a synchronous active-low reset, done_o is 0, every patch output is 0, and both CRC registers are zero, so a finish with no bytes fed gives a patch of 0.
- R2: Each forward byte XORs the byte into bits 7:0 of the forward register. It then does 8 right shifts, and each shift XORs in 0xEDB88320 when the bit shifted out was 1. The register starts at 0 and has no final XOR.
- R3: Each backward byte maps the backward register to the unique state that a forward step with that byte would carry back to the current value. The register starts at 0.
- R4: A finish pulse without start loads patch_word_o with the XOR of the forward and backward registers as they stood before that clock edge. done_o is 1 in exactly the following cycle.
- R5: patch_b0_o carries patch bits 7:0, patch_b1_o bits 15:8, patch_b2_o bits 23:16 and patch_b3_o bits 31:24. Lane 0 is written at the lowest address.
- R6: start_i clears both registers and takes priority over bytes and finish in the same cycle. Those bytes are dropped and that finish gives no done and no patch change.
- R7: Suppose the prefix goes to the forward register, the suffix goes to the backward register last byte first, and four zero bytes come last. Placing lanes 0..3 between prefix and suffix then gives a forward CRC of 0 over the complete sequence.
- R8: The patch outputs hold their value in every cycle that done_o is 0. A finish does not clear either register.
- R9: Bytes given in the same cycle as a finish (without start) are taken into the registers after the snapshot used for the patch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Clears both CRC registers |
| fwd_valid_i | input | 1 | fwd_byte_i holds a prefix byte |
| fwd_byte_i | input | 8 | Prefix byte, address order |
| rev_valid_i | input | 1 | rev_byte_i holds a suffix byte |
| rev_byte_i | input | 8 | Suffix byte, last address first, placeholder zeros last |
| finish_i | input | 1 | Capture the patch word |
| done_o | output | 1 | One-cycle pulse: patch outputs updated |
| patch_word_o | output | 32 | Patch word |
| patch_b0_o | output | 8 | Patch byte for the lowest address |
| patch_b1_o | output | 8 | Patch byte for address +1 |
| patch_b2_o | output | 8 | Patch byte for address +2 |
| patch_b3_o | output | 8 | Patch byte for address +3 |

## Verification
The hardest thing to show from the ports is that the backward register really undoes forward steps. Its value is never visible by itself, only XORed into the patch. The bench therefore closes the loop. It takes the patch from one run, builds the full sequence with the patch inserted, and runs that sequence through the forward register in a second run. That second run must give a zero patch. Short and empty prefixes and suffixes are covered, as are start and finish arriving in the same cycle as data bytes.

// File: rtl/crc_patch_pkg.sv
// Package: crc_patch_pkg
// Holds the widths, the default generator and the single-byte step functions
// that the forward and backward CRC registers of the patch solver share.
// Assumes a reflected (right-shifting) CRC with no input or output inversion.
package crc_patch_pkg;

    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = CRC_W / BYTE_W;
    localparam logic [CRC_W-1:0] DEFAULT_POLY = 32'hEDB8_8320;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // One forward byte: XOR into low bits, then BYTE_W right-shift steps.
    function automatic crc_t fwd_byte_step(input crc_t c, input byte_t b, input crc_t poly);
        crc_t r;
        r = c ^ {{(CRC_W-BYTE_W){1'b0}}, b};
        for (int k = 0; k < BYTE_W; k++) begin
            r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
        end
        return r;
    endfunction

    // One backward byte: BYTE_W inverse shift steps, then XOR out the byte.
    function automatic crc_t rev_byte_step(input crc_t c, input byte_t b, input crc_t poly);
        crc_t r;
        r = c;
        for (int k = 0; k < BYTE_W; k++) begin
            r = r[CRC_W-1] ? (((r ^ poly) << 1) | crc_t'(1)) : (r << 1);
        end
        r = r ^ {{(CRC_W-BYTE_W){1'b0}}, b};
        return r;
    endfunction

endpackage

// File: rtl/crc_fwd_engine.sv
// Module: crc_fwd_engine
// Forward CRC register. It takes one byte per valid cycle and updates with the
// reflected generator. clr_i zeroes the register and beats valid_i.
// Assumes bytes arrive in ascending address order.
module crc_fwd_engine
    import crc_patch_pkg::*;
#(
    parameter crc_t POLY = DEFAULT_POLY
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr_i,
    input  logic  valid_i,
    input  byte_t byte_i,
    output crc_t  crc_o
);

    crc_t crc_q;

    // Register update: reset or clear to zero, otherwise fold in the byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            crc_q <= '0;
        end else if (valid_i) begin
            crc_q <= fwd_byte_step(crc_q, byte_i, POLY);
        end
    end

    assign crc_o = crc_q;

    // R6: a clear leaves the register at zero
    assert_fwd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(clr_i) |-> crc_o == '0);

    // R2: register holds when no byte and no clear
    assert_fwd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(valid_i) && !$past(clr_i) |-> $stable(crc_o));

endmodule

// File: rtl/crc_rev_engine.sv
// Module: crc_rev_engine
// Backward CRC register. Each valid byte undoes one forward byte step, so
// after the tail is fed it holds the state the forward pass must reach.
// Assumes bytes arrive from the highest address down. The generator must
// have its top bit set, because the inverse step depends on that.
module crc_rev_engine
    import crc_patch_pkg::*;
#(
    parameter crc_t POLY = DEFAULT_POLY
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr_i,
    input  logic  valid_i,
    input  byte_t byte_i,
    output crc_t  crc_o
);

    crc_t crc_q;

    // Register update: reset or clear to zero, otherwise step one byte back.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            crc_q <= '0;
        end else if (valid_i) begin
            crc_q <= rev_byte_step(crc_q, byte_i, POLY);
        end
    end

    assign crc_o = crc_q;

    // R3: a forward step with the same byte returns the previous value
    assert_rev_roundtrip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(valid_i) && !$past(clr_i)
        |-> fwd_byte_step(crc_o, $past(byte_i), POLY) == $past(crc_o));

    // R6: a clear leaves the register at zero
    assert_rev_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(clr_i) |-> crc_o == '0);

endmodule

// File: rtl/crc_patch_out.sv
// Module: crc_patch_out
// Output register for the patch word. On an accepted finish it stores the XOR
// of both CRC registers and pulses done. It splits the word into byte lanes,
// lane 0 being the lowest address.
// Assumes the CRC inputs are the register values before the current edge.
module crc_patch_out
    import crc_patch_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  take_i,
    input  crc_t  fwd_crc_i,
    input  crc_t  rev_crc_i,
    output logic  done_o,
    output crc_t  word_o,
    output byte_t lane_o [LANES]
);

    crc_t word_q;
    logic done_q;

    // Capture the combined word and produce the one-cycle done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= take_i;
            if (take_i) begin
                word_q <= fwd_crc_i ^ rev_crc_i;
            end
        end
    end

    // Byte lanes in little-endian memory order.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_o[g] = word_q[g*BYTE_W +: BYTE_W];
    end

    assign word_o = word_q;
    assign done_o = done_q;

endmodule

// File: rtl/crc_midpatch_gen.sv
// Module: crc_midpatch_gen
// Top level of the mid-stream patch solver. It runs the forward and backward
// CRC registers, applies start priority, and registers the patch word.
// Assumes the caller feeds the four zero placeholder bytes last on the
// backward stream.
module crc_midpatch_gen
    import crc_patch_pkg::*;
#(
    parameter logic [31:0] POLY = 32'hEDB8_8320
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        fwd_valid_i,
    input  logic [7:0]  fwd_byte_i,
    input  logic        rev_valid_i,
    input  logic [7:0]  rev_byte_i,
    input  logic        finish_i,
    output logic        done_o,
    output logic [31:0] patch_word_o,
    output logic [7:0]  patch_b0_o,
    output logic [7:0]  patch_b1_o,
    output logic [7:0]  patch_b2_o,
    output logic [7:0]  patch_b3_o
);

    crc_t  fwd_crc;
    crc_t  rev_crc;
    byte_t lanes [LANES];
    logic  take;

    // Finish counts only when start is absent.
    assign take = finish_i && !start_i;

    crc_fwd_engine #(.POLY(POLY)) fwd_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_i),
        .valid_i (fwd_valid_i),
        .byte_i  (fwd_byte_i),
        .crc_o   (fwd_crc)
    );

    crc_rev_engine #(.POLY(POLY)) rev_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_i),
        .valid_i (rev_valid_i),
        .byte_i  (rev_byte_i),
        .crc_o   (rev_crc)
    );

    crc_patch_out out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .fwd_crc_i (fwd_crc),
        .rev_crc_i (rev_crc),
        .done_o    (done_o),
        .word_o    (patch_word_o),
        .lane_o    (lanes)
    );

    assign patch_b0_o = lanes[0];
    assign patch_b1_o = lanes[1];
    assign patch_b2_o = lanes[2];
    assign patch_b3_o = lanes[3];

    // R4: done only follows a finish without start
    assert_done_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && done_o |-> $past(finish_i) && !$past(start_i));

    // R8: patch holds whenever done is low
    assert_patch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !done_o |-> $stable(patch_word_o));

    // R5: lowest lane is the low byte of the word
    assert_lane_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        patch_b0_o == patch_word_o[7:0] && patch_b3_o == patch_word_o[31:24]);

endmodule

// File: tb/crc_midpatch_gen_tb_top.sv
`timescale 1ns/1ps
module crc_midpatch_gen_tb_top;

    localparam logic [31:0] P = 32'hEDB8_8320;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, fwd_valid_i = 1'b0, rev_valid_i = 1'b0, finish_i = 1'b0;
    logic [7:0]  fwd_byte_i = '0, rev_byte_i = '0;
    logic        done_o;
    logic [31:0] patch_word_o;
    logic [7:0]  patch_b0_o, patch_b1_o, patch_b2_o, patch_b3_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    crc_midpatch_gen dut_i (.*);

    // Behavioural reference: bit-serial forms, not the RTL byte functions.
    function automatic logic [31:0] m_fwd(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ b[i];
            r = r >> 1;
            if (fb) r = r ^ P;
        end
        return r;
    endfunction

    function automatic logic [31:0] m_rev(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[31];
            if (fb) r = r ^ P;
            r = (r << 1) | {31'b0, fb ^ b[i]};
        end
        return r;
    endfunction

    logic [31:0] e_fwd = '0, e_rev = '0, e_word = '0;
    logic        e_done = 1'b0;
    logic [31:0] last_patch = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Reference model update at the clock edge (inputs are stable then).
    always @(posedge clk) begin
        if (!rst_n) begin
            e_fwd = '0; e_rev = '0; e_word = '0; e_done = 1'b0;
        end else begin
            e_done = 1'b0;
            if (start_i) begin
                e_fwd = '0; e_rev = '0;
            end else begin
                if (finish_i) begin
                    e_word = e_fwd ^ e_rev;   // R9: snapshot before same-cycle bytes
                    e_done = 1'b1;
                end
                if (fwd_valid_i) e_fwd = m_fwd(e_fwd, fwd_byte_i);
                if (rev_valid_i) e_rev = m_rev(e_rev, rev_byte_i);
            end
        end
    end

    // Every-cycle comparison, 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk("R4 done", {31'b0, done_o}, {31'b0, e_done});
            chk("R4/R8 word", patch_word_o, e_word);
            chk("R5 lanes", {patch_b3_o, patch_b2_o, patch_b1_o, patch_b0_o}, e_word);
            if (done_o) last_patch = patch_word_o;
        end
    end

    task automatic cyc(input logic s, input logic fv, input logic [7:0] fb,
                       input logic rv, input logic [7:0] rb, input logic fin);
        @(negedge clk);
        start_i = s; fwd_valid_i = fv; fwd_byte_i = fb;
        rev_valid_i = rv; rev_byte_i = rb; finish_i = fin;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, 8'h00, 0);
    endtask

    // Solve a patch for prefix/suffix, then re-run the full stream forward.
    task automatic run_patch(input int plen, input int slen);
        byte unsigned pre[$], suf[$], rq[$], full[$];
        logic [31:0] pw, ref_crc;
        int n;
        for (int i = 0; i < plen; i++) pre.push_back(byte'($urandom));
        for (int i = 0; i < slen; i++) suf.push_back(byte'($urandom));
        for (int i = slen - 1; i >= 0; i--) rq.push_back(suf[i]);
        for (int i = 0; i < 4; i++) rq.push_back(8'h00);
        cyc(1, 0, 8'h00, 0, 8'h00, 0);
        n = (plen > rq.size()) ? plen : rq.size();
        for (int i = 0; i < n; i++)
            cyc(0, i < plen, (i < plen) ? pre[i] : 8'h00,
                i < rq.size(), (i < rq.size()) ? rq[i] : 8'h00, 0);
        cyc(0, 0, 8'h00, 0, 8'h00, 1);
        idle(2);
        pw = last_patch;
        full = pre;
        for (int i = 0; i < 4; i++) full.push_back(pw[i*8 +: 8]);
        foreach (suf[i]) full.push_back(suf[i]);
        ref_crc = '0;
        foreach (full[i]) ref_crc = m_fwd(ref_crc, full[i]);
        chk("R7 bench CRC of patched stream", ref_crc, 32'h0);
        cyc(1, 0, 8'h00, 0, 8'h00, 0);
        foreach (full[i]) cyc(0, 1, full[i], 0, 8'h00, 0);
        cyc(0, 0, 8'h00, 0, 8'h00, 1);
        idle(2);
        chk("R7 design CRC of patched stream (R2 R3)", last_patch, 32'h0);
    endtask

    initial begin
        #(200000 * 5.0);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        chk("R1 reset done", {31'b0, done_o}, 32'h0);
        chk("R1 reset word", patch_word_o, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        // R1: finish with nothing fed yields zero
        cyc(0, 0, 8'h00, 0, 8'h00, 1);
        idle(2);
        chk("R1 empty finish", last_patch, 32'h0);
        // R2: single known byte forward
        cyc(1, 0, 8'h00, 0, 8'h00, 0);
        cyc(0, 1, 8'h01, 0, 8'h00, 0);
        cyc(0, 0, 8'h00, 0, 8'h00, 1);
        idle(2);
        chk("R2 one byte 01", last_patch, 32'h7707_3096);
        // R8: finish does not clear; second finish gives same value
        cyc(0, 0, 8'h00, 0, 8'h00, 1);
        idle(2);
        chk("R8 registers kept", last_patch, 32'h7707_3096);
        // R9: byte in the finish cycle is absorbed after the snapshot
        cyc(0, 1, 8'hA5, 0, 8'h00, 1);
        idle(2);
        chk("R9 snapshot", last_patch, 32'h7707_3096);
        cyc(0, 0, 8'h00, 0, 8'h00, 1);
        idle(2);
        chk("R9 absorbed", last_patch, m_fwd(32'h7707_3096, 8'hA5));
        // R6: start beats same-cycle bytes and finish
        cyc(1, 1, 8'h3C, 1, 8'h5A, 1);
        @(posedge clk); #1;
        chk("R6 no done on start+finish", {31'b0, done_o}, 32'h0);
        cyc(0, 0, 8'h00, 0, 8'h00, 1);
        idle(2);
        chk("R6 registers cleared", last_patch, 32'h0);
        // R3: backward byte then forward of same byte returns to zero
        cyc(1, 0, 8'h00, 0, 8'h00, 0);
        cyc(0, 0, 8'h00, 1, 8'h77, 0);
        cyc(0, 1, 8'h00, 0, 8'h00, 1);
        idle(2);
        chk("R3 backward value", last_patch, m_rev(32'h0, 8'h77));
        // R7: patch solving for several shapes
        run_patch(0, 0);
        run_patch(1, 0);
        run_patch(0, 3);
        run_patch(5, 9);
        run_patch(16, 2);
        run_patch(7, 23);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule